// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block runs an external 14-bit parallel-output sampling converter over its start/end-of-conversion handshake. On a single-cycle request, or on a free-running tick set by a programmable period, it raises the converter's start line for a fixed number of system-clock cycles. It then waits for the end-of-conversion line to fall and reads the data word and the out-of-range flag. The data word is converted from one of six raw coding formats into a plain unsigned or two's-complement result, which is placed on a valid/ready output stream.

All converter inputs pass through a two-flop synchroniser, so the word is read two cycles after the falling edge is seen. The output-enable line stays high while idle and during the start pulse. This keeps the previous result on the converter side and the bus free until the conversion phase. Error flags stay set until reset. One reports a conversion that never ended. One reports a request made while busy. One reports a sample that replaced an unread one.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, adc_start is 0, adc_oe_n is 1, m_valid is 0 and err_timeout, err_overrun and err_drop are all 0.
- R2: A request seen while idle raises adc_start on the next clock edge and holds it high for exactly START_CYC (default 5) cycles. adc_oe_n stays 1 while adc_start is high.
- R3: While auto_en is 1, a request is generated every period_cyc cycles (period_cyc at least 2), so that consecutive rising edges of adc_start are exactly period_cyc cycles apart when each conversion finishes within the period.
- R4: A request (trig or periodic tick) seen while a conversion is in progress starts nothing and sets err_overrun, which stays 1 until reset.
- R5: m_valid rises on the fifth rising clock edge after the edge at which adc_eoc falls (two synchroniser stages, one for edge detection, two of settling). m_data reflects the bus word present after the fall, not the word of the previous conversion nor the word on the bus while adc_eoc was high.
- R6: m_ovf carries the adc_ovf level captured together with the data word.
- R7: fmt selects the raw coding. fmt[2]=1 means the raw word is bitwise complemented, and adc_code_sel equals fmt[2]. fmt[1:0]=00 (and 11) is straight binary, passed through as an unsigned value. 01 is offset binary, returned as two's complement by inverting bit 13. 10 is two's complement, passed through.
- R8: adc_oe_n is 0 from the end of the start pulse until the word is captured, and 1 otherwise.
- R9: If adc_eoc has not been seen to fall within TIMEOUT_CYC (default 40) cycles of the start edge, err_timeout is set and stays 1. No sample is produced, and the block returns to idle and accepts the next request.
- R10: m_valid, once high, stays high until m_ready is 1. A new capture while an unread sample is held replaces it and sets err_drop, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Single conversion request |
| auto_en | input | 1 | Enables periodic requests |
| period_cyc | input | 16 | Cycles between periodic requests |
| fmt | input | 3 | Raw coding selection |
| adc_start | output | 1 | Start-convert line to the converter |
| adc_oe_n | output | 1 | Converter output enable, active low |
| adc_code_sel | output | 1 | Coding-select line to the converter |
| adc_eoc | input | 1 | End-of-conversion line, high while busy |
| adc_data | input | 14 | Converter data bus |
| adc_ovf | input | 1 | Converter out-of-range flag |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample accepted |
| m_data | output | 14 | Normalised sample |
| m_ovf | output | 1 | Out-of-range flag of the sample |
| err_timeout | output | 1 | Sticky end-of-conversion timeout |
| err_overrun | output | 1 | Sticky request-while-busy flag |
| err_drop | output | 1 | Sticky overwritten-sample flag |

## Verification
The start pulse begins on the edge after the request is sampled and lasts five edges. The sample appears on the fifth edge after the edge that drops adc_eoc. The timeout flag is set about forty cycles after the start edge. Each of these is measured by a cycle counter that advances on the same edges as the converter model. The bench stamps the counter at the model's falling edge and at each start rise, and reads the outputs at the falling clock edge. Each measured interval is compared with the exact count above, not with a window. Stimulus changes only at falling edges, so each request lands on a known rising edge.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DW          = 14,
  parameter int START_CYC   = 5,
  parameter int TIMEOUT_CYC = 40,
  parameter int LATCH_DLY   = 2,
  parameter int RATE_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              auto_en,
  input  logic [RATE_W-1:0] period_cyc,
  input  logic [2:0]        fmt,
  output logic              adc_start,
  output logic              adc_oe_n,
  output logic              adc_code_sel,
  input  logic              adc_eoc,
  input  logic [DW-1:0]     adc_data,
  input  logic              adc_ovf,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DW-1:0]     m_data,
  output logic              m_ovf,
  output logic              err_timeout,
  output logic              err_overrun,
  output logic              err_drop
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int HW = $clog2(LATCH_DLY + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAIT, S_HOLD} st_t;

  st_t              state;
  logic [TW-1:0]    tcnt;
  logic [HW-1:0]    hcnt;
  logic [RATE_W-1:0] rcnt;
  logic [2:0]       eoc_sh;
  logic [DW:0]      d_s1, d_s2;
  logic [DW-1:0]    w_raw, w_norm;

  wire tick     = auto_en && (rcnt == period_cyc - RATE_W'(1));
  wire req      = trig | tick;
  wire eoc_fall = eoc_sh[2] & ~eoc_sh[1];
  wire cap      = (state == S_HOLD) && (hcnt == HW'(LATCH_DLY - 1));

  assign adc_start    = (state == S_PULSE);
  assign adc_oe_n     = !(state == S_WAIT || state == S_HOLD);
  assign adc_code_sel = fmt[2];

  always_comb begin
    w_raw  = fmt[2] ? ~d_s2[DW-1:0] : d_s2[DW-1:0];
    w_norm = w_raw;
    if (fmt[1:0] == 2'b01) w_norm[DW-1] = ~w_raw[DW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tcnt        <= '0;
      hcnt        <= '0;
      rcnt        <= '0;
      eoc_sh      <= '0;
      d_s1        <= '0;
      d_s2        <= '0;
      m_valid     <= 1'b0;
      m_data      <= '0;
      m_ovf       <= 1'b0;
      err_timeout <= 1'b0;
      err_overrun <= 1'b0;
      err_drop    <= 1'b0;
    end else begin
      eoc_sh <= {eoc_sh[1:0], adc_eoc};
      d_s1   <= {adc_ovf, adc_data};
      d_s2   <= d_s1;
      rcnt   <= (!auto_en || tick) ? '0 : rcnt + RATE_W'(1);

      if (req && state != S_IDLE) err_overrun <= 1'b1;

      case (state)
        S_IDLE: if (req) begin
          state <= S_PULSE;
          tcnt  <= '0;
        end
        S_PULSE: begin
          tcnt <= tcnt + TW'(1);
          if (tcnt == TW'(START_CYC - 1)) state <= S_WAIT;
        end
        S_WAIT: begin
          tcnt <= tcnt + TW'(1);
          if (eoc_fall) begin
            state <= S_HOLD;
            hcnt  <= '0;
          end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            state       <= S_IDLE;
            err_timeout <= 1'b1;
          end
        end
        default: begin
          if (cap) state <= S_IDLE;
          else     hcnt  <= hcnt + HW'(1);
        end
      endcase

      if (cap) begin
        m_valid <= 1'b1;
        m_data  <= w_norm;
        m_ovf   <= d_s2[DW];
        if (m_valid && !m_ready) err_drop <= 1'b1;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int START_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic adc_start,
  input logic adc_oe_n,
  input logic m_valid,
  input logic m_ready,
  input logic err_timeout,
  input logic err_overrun,
  input logic err_drop
);

  localparam int RW = $clog2(START_CYC + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= '0;
    else if (adc_start) run <= run + RW'(1);
    else                run <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_start) |-> run == RW'(START_CYC)); // R2
  AST_OE_OFF_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> adc_oe_n); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |=> err_overrun); // R4
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout); // R9
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop |=> err_drop); // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R10

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.START_CYC(START_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_oe_n(adc_oe_n),
  .m_valid(m_valid), .m_ready(m_ready), .err_timeout(err_timeout),
  .err_overrun(err_overrun), .err_drop(err_drop)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = 6;  // counter steps from fall edge to 5th later edge
  localparam int NVEC       = 14;
  // {fmt, raw, ovf, expected}
  localparam logic [31:0] VEC [NVEC] = '{
    {3'd0, 14'h3FFF, 1'b1, 14'h3FFF},
    {3'd0, 14'h0001, 1'b0, 14'h0001},
    {3'd4, 14'h0000, 1'b0, 14'h3FFF},
    {3'd4, 14'h3FFE, 1'b1, 14'h0001},
    {3'd1, 14'h2000, 1'b0, 14'h0000},
    {3'd1, 14'h3FFF, 1'b0, 14'h1FFF},
    {3'd1, 14'h0000, 1'b1, 14'h2000},
    {3'd5, 14'h1FFF, 1'b0, 14'h0000},
    {3'd5, 14'h0000, 1'b0, 14'h1FFF},
    {3'd5, 14'h3FFF, 1'b0, 14'h2000},
    {3'd2, 14'h1FFF, 1'b0, 14'h1FFF},
    {3'd2, 14'h2000, 1'b1, 14'h2000},
    {3'd6, 14'h0000, 1'b0, 14'h3FFF},
    {3'd6, 14'h3FFF, 1'b0, 14'h0000}
  };

  logic clk = 0, rst_n = 0, trig = 0, auto_en = 0, m_ready = 0;
  logic [15:0] period_cyc = 16'd60;
  logic [2:0]  fmt = 3'd0;
  logic adc_start, adc_oe_n, adc_code_sel, m_valid, m_ovf;
  logic err_timeout, err_overrun, err_drop;
  logic [13:0] m_data;
  logic adc_eoc = 0, adc_ovf_q = 0;
  logic [13:0] bus = 14'h0, pend_code = 14'h0;
  logic pend_ovf = 0, stuck = 0, running = 0, start_d = 0;
  int cyc = 0, k = 0, fall_at = 0, rise_at = 0, rise_cnt = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  wire [13:0] adc_data = adc_oe_n ? 14'h2AAA : bus;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .auto_en(auto_en),
    .period_cyc(period_cyc), .fmt(fmt), .adc_start(adc_start),
    .adc_oe_n(adc_oe_n), .adc_code_sel(adc_code_sel), .adc_eoc(adc_eoc),
    .adc_data(adc_data), .adc_ovf(adc_ovf_q), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_ovf(m_ovf),
    .err_timeout(err_timeout), .err_overrun(err_overrun), .err_drop(err_drop)
  );

  // converter pin model
  always @(posedge clk) begin
    cyc     <= cyc + 1;
    start_d <= adc_start;
    if (adc_start && !start_d) begin
      running  <= 1;
      k        <= 0;
      rise_at  <= cyc;
      rise_cnt <= rise_cnt + 1;
    end else if (running) begin
      k <= k + 1;
      if (k == 2) adc_eoc <= 1;
      if (k == 9) bus <= 14'h1555;
      if (k >= 31 && !stuck) begin
        adc_eoc   <= 0;
        bus       <= pend_code;
        adc_ovf_q <= pend_ovf;
        running   <= 0;
        fall_at   <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 120 && !got; i++) begin
      @(negedge clk);
      if (m_valid) got = 1;
    end
  endtask

  task automatic accept();
    m_ready = 1;
    @(negedge clk) m_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    int w, r0, rc, t0, t1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_start == 0 && adc_oe_n == 1 && m_valid == 0, "R1 outputs", {adc_start, adc_oe_n, m_valid}, 3'b010);
    chk({err_timeout, err_overrun, err_drop} == 0, "R1 flags", {err_timeout, err_overrun, err_drop}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(adc_oe_n == 1, "R8 idle oe_n", adc_oe_n, 1);

    // vector loop: R2 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      bit oe_low_busy;
      fmt       = VEC[v][31:29];
      pend_code = VEC[v][28:15];
      pend_ovf  = VEC[v][14];
      fire();
      w = 0;
      oe_low_busy = 1;
      while (adc_start) begin
        w++;
        if (!adc_oe_n) oe_low_busy = 0;
        @(negedge clk);
      end
      chk(w == 5, "R2 start width", w, 5);
      chk(oe_low_busy, "R2 oe_n high in pulse", oe_low_busy, 1);
      @(negedge clk);
      chk(adc_oe_n == 0, "R8 oe_n low after pulse", adc_oe_n, 0);
      wait_valid(got);
      chk(got && (cyc - fall_at) == EXP_LAT, "R5 latency", cyc - fall_at, EXP_LAT);
      chk(m_data == VEC[v][13:0], "R7 R5 data", m_data, VEC[v][13:0]);
      chk(m_ovf == VEC[v][14], "R6 ovf", m_ovf, VEC[v][14]);
      chk(adc_code_sel == VEC[v][31], "R7 code_sel", adc_code_sel, VEC[v][31]);
      chk(adc_oe_n == 1, "R8 oe_n after capture", adc_oe_n, 1);
      accept();
      chk(m_valid == 0, "R10 valid cleared", m_valid, 0);
    end

    // R4 overrun
    fmt = 3'd0; pend_code = 14'h0ABC; pend_ovf = 0;
    chk(err_overrun == 0, "R4 no overrun yet", err_overrun, 1'b0);
    r0 = rise_cnt;
    fire();
    repeat (12) @(negedge clk);
    fire();
    wait_valid(got);
    repeat (20) @(negedge clk);
    chk(rise_cnt - r0 == 1, "R4 single start", rise_cnt - r0, 1);
    chk(err_overrun == 1, "R4 overrun flag", err_overrun, 1);
    chk(m_data == 14'h0ABC, "R4 sample", m_data, 14'h0ABC);
    accept();

    // R10 hold and drop
    chk(err_drop == 0, "R10 no drop yet", err_drop, 0);
    pend_code = 14'h0111;
    fire();
    wait_valid(got);
    repeat (30) @(negedge clk);
    chk(m_valid == 1 && m_data == 14'h0111, "R10 valid held", m_data, 14'h0111);
    pend_code = 14'h0222;
    fire();
    repeat (60) @(negedge clk);
    chk(m_data == 14'h0222 && m_valid, "R10 overwrite", m_data, 14'h0222);
    chk(err_drop == 1, "R10 drop flag", err_drop, 1);
    accept();

    // R9 timeout
    chk(err_timeout == 0, "R9 no timeout yet", err_timeout, 0);
    stuck = 1;
    fire();
    repeat (60) @(negedge clk);
    chk(err_timeout == 1, "R9 timeout flag", err_timeout, 1);
    chk(m_valid == 0, "R9 no sample", m_valid, 0);
    stuck = 0;
    repeat (20) @(negedge clk);
    chk(m_valid == 0, "R9 late fall ignored", m_valid, 0);
    pend_code = 14'h0333;
    fire();
    wait_valid(got);
    chk(got && m_data == 14'h0333, "R9 recovery", m_data, 14'h0333);
    accept();

    // R3 periodic requests
    m_ready = 1;
    period_cyc = 16'd60;
    auto_en = 1;
    rc = rise_cnt;
    while (rise_cnt == rc) @(negedge clk);
    t0 = rise_at;
    rc = rise_cnt;
    while (rise_cnt == rc) @(negedge clk);
    t1 = rise_at;
    chk(t1 - t0 == 60, "R3 period", t1 - t0, 60);
    t0 = t1;
    rc = rise_cnt;
    while (rise_cnt == rc) @(negedge clk);
    chk(rise_at - t0 == 60, "R3 period repeat", rise_at - t0, 60);
    auto_en = 0;
    repeat (60) @(negedge clk);
    m_ready = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule